// File: doc/BRIEF.md
# Fully Associative Multi-Page-Size Translation Buffer

This block turns a virtual address into a 36-bit real address. The virtual address has 41 bits: a 32-bit effective address, an 8-bit process identifier and a single address-space bit. The buffer is fully associative. Any entry can hold any page, and each entry matches at its own page size. The eight sizes are 1KB, 4KB, 16KB, 64KB, 256KB, 1MB, 16MB and 256MB, and entries of different sizes can sit side by side. A lookup is purely combinational. In the same cycle it reports a hit, an instruction-side or data-side miss, a permission fault, a multi-hit flag and a machine-check flag for a parity mismatch. On a hit it also returns the real address and the entry's storage attributes.

Software loads and inspects entries through a privileged port. A write takes effect at the clock edge that accepts it. A read is handled by a two-state machine. `ST_IDLE` moves to `ST_RESP` on an accepted read (transition *read_accept*). `ST_RESP` stays in `ST_RESP` on a further accepted read (*read_again*) and returns to `ST_IDLE` otherwise (*read_done*). `ST_IDLE` stays put when no read is accepted (*idle_hold*). The read data is presented while in `ST_RESP`. Requests made without the supervisor input are dropped.

Top module: `tlb_xlate_top`

## Requirements
- R1: An entry word is packed MSB first as: valid(1), size(3), space(1), pid(8), epn(22, equal to effective address bits 31:10), tag parity(1), rpn(26, equal to real address bits 35:10), perm(6), attr(8), data parity(1), for 77 bits in total. A supervisor write (`sw_req`=1, `sw_we`=1) stores the word at `sw_idx`. A supervisor read (`sw_we`=0) sets `sw_rvalid` in the following cycle, with `sw_rdata` equal to that entry. `sw_rdata` is zero whenever `sw_rvalid` is low.
- R2: A write or read made with `sw_super`=0 is ignored. The entry keeps its value, and no `sw_rvalid` follows.
- R3: Reset clears every entry, so every lookup misses until entries are written.
- R4: An entry matches when all of the following hold: it is valid; its space bit equals the lookup space; its pid equals `lk_pid`; and its epn equals the effective address at every bit above the page offset. The size code k gives offset widths of 10, 12, 14, 16, 18, 20, 24 and 28 bits for k = 0 to 7. `lk_hit` is set when some entry matches.
- R5: On a hit, `lk_ra` takes its bits above the offset from the entry's real page number and its offset bits from `lk_ea`. The result is zero on a miss.
- R6: The lookup space bit is `lk_is` when `lk_fetch`=1, and `lk_ds` otherwise.
- R7: A valid lookup with no match raises `lk_imiss` for a fetch and `lk_dmiss` for a load or store.
- R8: perm bits 5..0 are supervisor read, supervisor write, supervisor execute, user read, user write and user execute. A fetch needs execute, a store (`lk_store`=1) needs write, and a load needs read, using the supervisor bits when `lk_super`=1. On a hit that lacks the needed bit, the block raises `lk_ifault` for a fetch and `lk_dfault` otherwise.
- R9: On a hit, `lk_attr` carries the entry's 8 attribute bits: bit7 cacheable, bit6 write-through, bit5 little-endian, bit4 speculative, bits 3:0 user-defined. It is zero on a miss.
- R10: When two or more entries match, `lk_multi` is set and the lowest-index matching entry supplies the result.
- R11: The tag parity bit is the XOR of valid, size, space, pid and epn. The data parity bit is the XOR of rpn, perm and attr. On a hit where the selected entry fails either parity check, `lk_mcheck` is set.
- R12: While `lk_valid`=0 every lookup output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sw_req | input | 1 | Software access request |
| sw_we | input | 1 | 1 = write, 0 = read |
| sw_super | input | 1 | Supervisor state for the access |
| sw_idx | input | 6 | Entry index |
| sw_wdata | input | 77 | Entry word to write |
| sw_rvalid | output | 1 | Read data valid |
| sw_rdata | output | 77 | Entry word read |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address |
| lk_pid | input | 8 | Process identifier |
| lk_is | input | 1 | Instruction address space |
| lk_ds | input | 1 | Data address space |
| lk_fetch | input | 1 | 1 = instruction fetch |
| lk_store | input | 1 | 1 = store (data side) |
| lk_super | input | 1 | Supervisor state for the lookup |
| lk_hit | output | 1 | Matching entry found |
| lk_ra | output | 36 | Real address |
| lk_attr | output | 8 | Storage attributes |
| lk_imiss | output | 1 | Instruction-side miss |
| lk_dmiss | output | 1 | Data-side miss |
| lk_ifault | output | 1 | Instruction-side permission fault |
| lk_dfault | output | 1 | Data-side permission fault |
| lk_multi | output | 1 | More than one entry matched |
| lk_mcheck | output | 1 | Parity error on the selected entry |

## Verification
Lookup results are combinational, so they are due in the same cycle the lookup inputs are driven. Read data appears one clock edge after the request is captured, and an entry write is visible to lookups from the cycle after it is accepted. The driver applies each stimulus at a falling edge and queues exactly one expected item for it. The monitor pops that item two nanoseconds after the next rising edge, which is when both the combinational results and the registered read response are settled.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int EA_W     = 32;
    localparam int PID_W    = 8;
    localparam int RA_W     = 36;
    localparam int BASE_OFF = 10;
    localparam int EPN_W    = EA_W - BASE_OFF;
    localparam int RPN_W    = RA_W - BASE_OFF;
    localparam int SZ_W     = 3;
    localparam int PERM_W   = 6;
    localparam int ATTR_W   = 8;

    localparam int P_UX = 0;
    localparam int P_UW = 1;
    localparam int P_UR = 2;
    localparam int P_SX = 3;
    localparam int P_SW = 4;
    localparam int P_SR = 5;

    typedef struct packed {
        logic              valid;
        logic [SZ_W-1:0]   size;
        logic              as_id;
        logic [PID_W-1:0]  pid;
        logic [EPN_W-1:0]  epn;
        logic              tpar;
        logic [RPN_W-1:0]  rpn;
        logic [PERM_W-1:0] perm;
        logic [ATTR_W-1:0] attr;
        logic              dpar;
    } tlb_entry_t;

    localparam int ENT_W = $bits(tlb_entry_t);

    typedef enum logic {ST_IDLE, ST_RESP} sw_state_e;

    // low-order mask covering the page offset of a size code
    function automatic logic [RA_W-1:0] offset_mask(input logic [SZ_W-1:0] sz);
        int unsigned bits;
        if (sz < 3'd6)       bits = BASE_OFF + 2 * 32'(sz);
        else if (sz == 3'd6) bits = 24;
        else                 bits = 28;
        return (RA_W'(1) << bits) - RA_W'(1);
    endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  tlb_entry_t             wr_data,
    input  logic [IDX_W-1:0]       rd_idx,
    output tlb_entry_t             rd_data,
    output tlb_entry_t [N_ENT-1:0] ents
);
    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ents[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                ents[g] <= wr_data;
        end
    end

    assign rd_data = ents[rd_idx];
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  tlb_entry_t [N_ENT-1:0] ents,
    input  logic [EA_W-1:0]        ea,
    input  logic [PID_W-1:0]       pid,
    input  logic                   as_id,
    output logic                   hit,
    output logic [IDX_W-1:0]       sel_idx,
    output logic                   multi
);
    logic [N_ENT-1:0] match;

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        logic [EA_W-1:0] keep;
        logic [EA_W-1:0] diff;
        assign keep = ~EA_W'(offset_mask(ents[g].size));
        assign diff = (ea ^ {ents[g].epn, {BASE_OFF{1'b0}}}) & keep;
        assign match[g] = ents[g].valid && (ents[g].as_id == as_id) &&
                          (ents[g].pid == pid) && (diff == '0);
    end

    always_comb begin
        logic found;
        found   = 1'b0;
        sel_idx = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (match[i] && !found) begin
                sel_idx = IDX_W'(i);
                found   = 1'b1;
            end
        end
    end

    assign hit   = |match;
    assign multi = $countones(match) > 1;
endmodule

// File: rtl/tlb_check.sv
module tlb_check
    import tlb_pkg::*;
(
    input  tlb_entry_t         ent,
    input  logic               hit,
    input  logic               lk_valid,
    input  logic [EA_W-1:0]    ea,
    input  logic               fetch,
    input  logic               store,
    input  logic               super_st,
    output logic [RA_W-1:0]    ra,
    output logic [ATTR_W-1:0]  attr,
    output logic               imiss,
    output logic               dmiss,
    output logic               ifault,
    output logic               dfault,
    output logic               mcheck
);
    logic            hit_v;
    logic            allowed;
    logic            tbad;
    logic            dbad;
    logic [RA_W-1:0] mask;

    assign hit_v = lk_valid && hit;
    assign mask  = offset_mask(ent.size);

    always_comb begin
        if (super_st)
            allowed = fetch ? ent.perm[P_SX] : (store ? ent.perm[P_SW] : ent.perm[P_SR]);
        else
            allowed = fetch ? ent.perm[P_UX] : (store ? ent.perm[P_UW] : ent.perm[P_UR]);
    end

    assign tbad = ^{ent.valid, ent.size, ent.as_id, ent.pid, ent.epn, ent.tpar};
    assign dbad = ^{ent.rpn, ent.perm, ent.attr, ent.dpar};

    assign ra = hit_v ? (({ent.rpn, {BASE_OFF{1'b0}}} & ~mask) |
                         ({{(RA_W-EA_W){1'b0}}, ea} & mask)) : '0;
    assign attr   = hit_v ? ent.attr : '0;
    assign imiss  = lk_valid && !hit && fetch;
    assign dmiss  = lk_valid && !hit && !fetch;
    assign ifault = hit_v && !allowed && fetch;
    assign dfault = hit_v && !allowed && !fetch;
    assign mcheck = hit_v && (tbad || dbad);
endmodule

// File: rtl/tlb_xlate_top.sv
module tlb_xlate_top
    import tlb_pkg::*;
#(
    parameter int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_req,
    input  logic               sw_we,
    input  logic               sw_super,
    input  logic [IDX_W-1:0]   sw_idx,
    input  logic [ENT_W-1:0]   sw_wdata,
    output logic               sw_rvalid,
    output logic [ENT_W-1:0]   sw_rdata,
    input  logic               lk_valid,
    input  logic [EA_W-1:0]    lk_ea,
    input  logic [PID_W-1:0]   lk_pid,
    input  logic               lk_is,
    input  logic               lk_ds,
    input  logic               lk_fetch,
    input  logic               lk_store,
    input  logic               lk_super,
    output logic               lk_hit,
    output logic [RA_W-1:0]    lk_ra,
    output logic [ATTR_W-1:0]  lk_attr,
    output logic               lk_imiss,
    output logic               lk_dmiss,
    output logic               lk_ifault,
    output logic               lk_dfault,
    output logic               lk_multi,
    output logic               lk_mcheck
);
    sw_state_e              state_q;
    sw_state_e              state_d;
    logic [IDX_W-1:0]       rd_idx_q;
    logic                   rd_go;
    logic                   wr_go;
    tlb_entry_t             rd_ent;
    tlb_entry_t [N_ENT-1:0] ents;
    logic                   hit;
    logic                   multi;
    logic [IDX_W-1:0]       sel_idx;
    logic                   as_sel;

    assign rd_go  = sw_req && !sw_we && sw_super;
    assign wr_go  = sw_req && sw_we && sw_super;
    assign as_sel = lk_fetch ? lk_is : lk_ds;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            rd_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_go)
                rd_idx_q <= sw_idx;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_go ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_go ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sw_rvalid = (state_q == ST_RESP);
        sw_rdata  = sw_rvalid ? ENT_W'(rd_ent) : '0;
    end

    tlb_entry_store #(.N_ENT(N_ENT)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_go),
        .wr_idx  (sw_idx),
        .wr_data (tlb_entry_t'(sw_wdata)),
        .rd_idx  (rd_idx_q),
        .rd_data (rd_ent),
        .ents    (ents)
    );

    tlb_match #(.N_ENT(N_ENT)) u_match (
        .ents    (ents),
        .ea      (lk_ea),
        .pid     (lk_pid),
        .as_id   (as_sel),
        .hit     (hit),
        .sel_idx (sel_idx),
        .multi   (multi)
    );

    tlb_check u_check (
        .ent      (ents[sel_idx]),
        .hit      (hit),
        .lk_valid (lk_valid),
        .ea       (lk_ea),
        .fetch    (lk_fetch),
        .store    (lk_store),
        .super_st (lk_super),
        .ra       (lk_ra),
        .attr     (lk_attr),
        .imiss    (lk_imiss),
        .dmiss    (lk_dmiss),
        .ifault   (lk_ifault),
        .dfault   (lk_dfault),
        .mcheck   (lk_mcheck)
    );

    assign lk_hit   = lk_valid && hit;
    assign lk_multi = lk_valid && multi;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
    import tlb_pkg::*;
#(
    parameter int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_req,
    input logic              sw_we,
    input logic              sw_super,
    input logic              sw_rvalid,
    input logic [ENT_W-1:0]  sw_rdata,
    input logic              lk_valid,
    input logic              lk_fetch,
    input logic              lk_hit,
    input logic [RA_W-1:0]   lk_ra,
    input logic              lk_imiss,
    input logic              lk_dmiss,
    input logic              lk_ifault,
    input logic              lk_dfault,
    input logic              lk_multi,
    input logic              lk_mcheck
);
    p_rvalid_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && !sw_we && sw_super) |=> sw_rvalid);

    p_rdata_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_rvalid |-> (sw_rdata == '0));

    p_no_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_req && !sw_we && sw_super) |=> !sw_rvalid);

    p_hit_miss_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (lk_hit != (lk_imiss || lk_dmiss)));

    p_imiss_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_imiss |-> lk_fetch);

    p_dmiss_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_dmiss |-> !lk_fetch);

    p_fault_needs_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_ifault || lk_dfault) |-> lk_hit);

    p_multi_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_multi |-> lk_hit);

    p_mcheck_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lk_mcheck |-> lk_hit);

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_imiss && !lk_dmiss && !lk_ifault &&
                       !lk_dfault && !lk_multi && !lk_mcheck && lk_ra == '0));
endmodule

bind tlb_xlate_top tlb_xlate_chk #(.N_ENT(N_ENT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_req    (sw_req),
    .sw_we     (sw_we),
    .sw_super  (sw_super),
    .sw_rvalid (sw_rvalid),
    .sw_rdata  (sw_rdata),
    .lk_valid  (lk_valid),
    .lk_fetch  (lk_fetch),
    .lk_hit    (lk_hit),
    .lk_ra     (lk_ra),
    .lk_imiss  (lk_imiss),
    .lk_dmiss  (lk_dmiss),
    .lk_ifault (lk_ifault),
    .lk_dfault (lk_dfault),
    .lk_multi  (lk_multi),
    .lk_mcheck (lk_mcheck)
);

// File: tb/tlb_xlate_top_tb_top.sv
module tlb_xlate_top_tb_top;
    import tlb_pkg::*;

    localparam int N = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sw_req = 1'b0, sw_we = 1'b0, sw_super = 1'b0;
    logic [5:0]        sw_idx = '0;
    logic [ENT_W-1:0]  sw_wdata = '0;
    logic              sw_rvalid;
    logic [ENT_W-1:0]  sw_rdata;
    logic              lk_valid = 1'b0;
    logic [31:0]       lk_ea = '0;
    logic [7:0]        lk_pid = '0;
    logic              lk_is = 1'b0, lk_ds = 1'b0, lk_fetch = 1'b0, lk_store = 1'b0, lk_super = 1'b0;
    logic              lk_hit, lk_imiss, lk_dmiss, lk_ifault, lk_dfault, lk_multi, lk_mcheck;
    logic [35:0]       lk_ra;
    logic [7:0]        lk_attr;

    always #4 clk = ~clk;

    tlb_xlate_top #(.N_ENT(N)) dut_i (.*);

    typedef struct {
        int          kind;   // 0 no read response, 1 lookup, 2 read response
        string       req;
        logic [50:0] lk;
        logic        rv;
        logic [ENT_W-1:0] rd;
    } exp_t;

    exp_t       sb[$];
    tlb_entry_t shadow [N];
    int         n_chk = 0;
    int         n_fail = 0;

    function automatic int off_bits(input logic [2:0] sz);
        if (sz < 3'd6) return 10 + 2 * int'(sz);
        return (sz == 3'd6) ? 24 : 28;
    endfunction

    function automatic tlb_entry_t mk(input logic v, input logic [2:0] sz, input logic as_id,
                                      input logic [7:0] pid, input logic [31:0] ea,
                                      input logic [35:0] ra, input logic [5:0] perm,
                                      input logic [7:0] attr, input logic flip_t, input logic flip_d);
        tlb_entry_t e;
        e.valid = v; e.size = sz; e.as_id = as_id; e.pid = pid;
        e.epn = ea[31:10]; e.rpn = ra[35:10]; e.perm = perm; e.attr = attr;
        e.tpar = (^{v, sz, as_id, pid, ea[31:10]}) ^ flip_t;
        e.dpar = (^{ra[35:10], perm, attr}) ^ flip_d;
        return e;
    endfunction

    // reference model built from the requirements
    function automatic logic [50:0] model(input logic v, input logic [31:0] ea, input logic [7:0] pid,
                                          input logic as_id, input logic fetch, input logic store,
                                          input logic sup);
        int cnt = 0, sel = -1, b;
        logic [35:0] ra = '0, lowm;
        logic [7:0] attr = '0;
        logic ok, hit, bad;
        if (!v) return '0;
        for (int i = 0; i < N; i++) begin
            b = off_bits(shadow[i].size);
            if (shadow[i].valid && shadow[i].as_id == as_id && shadow[i].pid == pid &&
                (ea >> b) == ({shadow[i].epn, 10'b0} >> b)) begin
                cnt++;
                if (sel < 0) sel = i;
            end
        end
        hit = (cnt > 0);
        ok = 1'b0; bad = 1'b0;
        if (hit) begin
            b = off_bits(shadow[sel].size);
            lowm = (36'd1 << b) - 36'd1;
            ra = ({shadow[sel].rpn, 10'b0} & ~lowm) | ({4'b0, ea} & lowm);
            attr = shadow[sel].attr;
            if (fetch)      ok = sup ? shadow[sel].perm[3] : shadow[sel].perm[0];
            else if (store) ok = sup ? shadow[sel].perm[4] : shadow[sel].perm[1];
            else            ok = sup ? shadow[sel].perm[5] : shadow[sel].perm[2];
            bad = (^{shadow[sel].valid, shadow[sel].size, shadow[sel].as_id, shadow[sel].pid,
                     shadow[sel].epn, shadow[sel].tpar}) |
                  (^{shadow[sel].rpn, shadow[sel].perm, shadow[sel].attr, shadow[sel].dpar});
        end
        return {hit, ra, attr, !hit && fetch, !hit && !fetch, hit && !ok && fetch,
                hit && !ok && !fetch, cnt > 1, hit && bad};
    endfunction

    task automatic do_lookup(input string req, input logic v, input logic [31:0] ea,
                             input logic [7:0] pid, input logic is_b, input logic ds_b,
                             input logic fetch, input logic store, input logic sup);
        exp_t e;
        @(negedge clk);
        sw_req = 1'b0; sw_we = 1'b0;
        lk_valid = v; lk_ea = ea; lk_pid = pid; lk_is = is_b; lk_ds = ds_b;
        lk_fetch = fetch; lk_store = store; lk_super = sup;
        e.kind = 1; e.req = req; e.rv = 1'b0; e.rd = '0;
        e.lk = model(v, ea, pid, fetch ? is_b : ds_b, fetch, store, sup);
        sb.push_back(e);
    endtask

    task automatic do_write(input string req, input logic sup, input int idx, input tlb_entry_t ent);
        exp_t e;
        @(negedge clk);
        lk_valid = 1'b0;
        sw_req = 1'b1; sw_we = 1'b1; sw_super = sup; sw_idx = 6'(idx); sw_wdata = ent;
        if (sup) shadow[idx] = ent;
        e.kind = 0; e.req = req; e.lk = '0; e.rv = 1'b0; e.rd = '0;
        sb.push_back(e);
    endtask

    task automatic do_read(input string req, input logic sup, input int idx);
        exp_t e;
        @(negedge clk);
        lk_valid = 1'b0;
        sw_req = 1'b1; sw_we = 1'b0; sw_super = sup; sw_idx = 6'(idx); sw_wdata = '0;
        e.kind = 2; e.req = req; e.lk = '0; e.rv = sup; e.rd = sup ? ENT_W'(shadow[idx]) : '0;
        sb.push_back(e);
    endtask

    // monitor: one expected item per cycle
    initial begin
        exp_t e;
        logic [50:0] obs;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                n_chk++;
                if (e.kind == 1) begin
                    obs = {lk_hit, lk_ra, lk_attr, lk_imiss, lk_dmiss, lk_ifault, lk_dfault,
                           lk_multi, lk_mcheck};
                    if (obs !== e.lk) begin
                        n_fail++;
                        $display("FAIL %s lookup: actual %h expected %h", e.req, obs, e.lk);
                    end
                end else if (sw_rvalid !== e.rv || sw_rdata !== e.rd) begin
                    n_fail++;
                    $display("FAIL %s read port: actual rv=%b %h expected rv=%b %h",
                             e.req, sw_rvalid, sw_rdata, e.rv, e.rd);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] base;
        int b;
        for (int i = 0; i < N; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3: empty after reset
        do_lookup("R3", 1, 32'h1234_5ABC, 8'd5, 0, 0, 0, 0, 0);
        do_lookup("R3", 1, 32'h0, 8'd0, 0, 0, 1, 0, 1);
        do_read("R3", 1, 63);

        // R1/R4/R5/R9: 4KB entry, user read only
        do_write("R1", 1, 0, mk(1, 3'd1, 0, 8'd5, 32'h1234_5000, 36'hA_BCDE_F000, 6'b000100, 8'hA5, 0, 0));
        do_read("R1", 1, 0);
        do_lookup("R5", 1, 32'h1234_5ABC, 8'd5, 0, 0, 0, 0, 0);
        do_lookup("R9", 1, 32'h1234_5FFF, 8'd5, 0, 0, 0, 0, 0);
        do_lookup("R4", 1, 32'h1234_6000, 8'd5, 0, 0, 0, 0, 0);
        do_lookup("R4", 1, 32'h1234_5000, 8'd6, 0, 0, 0, 0, 0);
        // R8: permissions
        do_lookup("R8", 1, 32'h1234_5004, 8'd5, 0, 0, 0, 1, 0);
        do_lookup("R8", 1, 32'h1234_5008, 8'd5, 0, 0, 1, 0, 0);
        do_lookup("R8", 1, 32'h1234_500C, 8'd5, 0, 0, 0, 0, 1);
        // R12: lookup idle
        do_lookup("R12", 0, 32'h1234_5ABC, 8'd5, 0, 0, 0, 0, 0);

        // R2: unprivileged accesses ignored
        do_write("R2", 0, 1, mk(1, 3'd1, 0, 8'd50, 32'h2000_0000, 36'h1_0000_0000, 6'h3F, 8'h0F, 0, 0));
        do_lookup("R2", 1, 32'h2000_0010, 8'd50, 0, 0, 0, 0, 0);
        do_read("R2", 1, 1);
        do_read("R2", 0, 0);
        do_write("R2", 0, 0, '0);
        do_lookup("R2", 1, 32'h1234_5ABC, 8'd5, 0, 0, 0, 0, 0);

        // R6/R7: 256MB page in space 1
        do_write("R6", 1, 2, mk(1, 3'd7, 1, 8'd9, 32'h3000_0000, 36'hF_0000_0000, 6'h3F, 8'h5A, 0, 0));
        do_lookup("R6", 1, 32'h3ABC_DEF0, 8'd9, 1, 0, 1, 0, 0);
        do_lookup("R7", 1, 32'h3ABC_DEF0, 8'd9, 0, 1, 1, 0, 0);
        do_lookup("R6", 1, 32'h3FFF_FFFC, 8'd9, 0, 1, 0, 1, 1);
        do_lookup("R7", 1, 32'h3000_0000, 8'd8, 1, 1, 0, 0, 0);

        // R4: 1KB page boundaries
        do_write("R4", 1, 3, mk(1, 3'd0, 0, 8'd1, 32'h0000_0400, 36'h0_0000_0C00, 6'h3F, 8'h81, 0, 0));
        do_lookup("R4", 1, 32'h0000_07FF, 8'd1, 0, 0, 0, 0, 0);
        do_lookup("R4", 1, 32'h0000_0800, 8'd1, 0, 0, 0, 0, 0);
        do_lookup("R4", 1, 32'h0000_03FF, 8'd1, 0, 0, 1, 0, 0);

        // R4/R5: remaining size codes at their page edges
        for (int s = 2; s <= 6; s++) begin
            base = 32'h4000_0000 + 32'(s) * 32'h0100_0000;
            b = off_bits(3'(s));
            do_write("R4", 1, 8 + s, mk(1, 3'(s), 0, 8'(20 + s), base, 36'h8_0000_0000 + 36'(base),
                                      6'h3F, 8'(s), 0, 0));
            do_lookup("R5", 1, base + (32'd1 << b) - 32'd1, 8'(20 + s), 0, 0, 0, 0, 0);
            do_lookup("R4", 1, base + (32'd1 << b), 8'(20 + s), 0, 0, 0, 0, 0);
        end

        // R10: two matching entries, lowest index wins
        do_write("R10", 1, 21, mk(1, 3'd2, 0, 8'd30, 32'h5000_0000, 36'h1_1111_0000, 6'h3F, 8'h11, 0, 0));
        do_write("R10", 1, 20, mk(1, 3'd2, 0, 8'd30, 32'h5000_0000, 36'h2_2222_0000, 6'h3F, 8'h22, 0, 0));
        do_lookup("R10", 1, 32'h5000_1234, 8'd30, 0, 0, 0, 0, 0);

        // R11: parity errors on tag and data
        do_write("R11", 1, 30, mk(1, 3'd1, 0, 8'd40, 32'h6000_0000, 36'h3_0000_0000, 6'h3F, 8'h33, 1, 0));
        do_write("R11", 1, 31, mk(1, 3'd1, 0, 8'd41, 32'h6000_0000, 36'h3_0000_0000, 6'h3F, 8'h33, 0, 1));
        do_lookup("R11", 1, 32'h6000_0100, 8'd40, 0, 0, 0, 0, 0);
        do_lookup("R11", 1, 32'h6000_0100, 8'd41, 0, 0, 0, 0, 0);
        do_read("R11", 1, 31);

        // R1: invalidate by overwrite, back-to-back reads
        do_write("R1", 1, 0, '0);
        do_lookup("R1", 1, 32'h1234_5ABC, 8'd5, 0, 0, 0, 0, 0);
        do_read("R1", 1, 2);
        do_read("R1", 1, 3);
        do_lookup("R12", 0, 32'h0, 8'd0, 0, 0, 0, 0, 0);

        @(negedge clk);
        sw_req = 1'b0; lk_valid = 1'b0;
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule